// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a four-beat burst. An access starts when either of two active-low start strobes is asserted at a clock rise. The block then captures the full input address. The bits above the burst field go into a base register. The low burst field goes into a start register, and a step counter is cleared. Each later clock rise with the active-low advance input asserted moves the step counter on by one. The burst field of the output is formed from the start value and the step count.

A static order-select input chooses between two orders:
- **Linear:** the start value plus the step count, modulo the burst length.
- **Interleaved:** the start value XOR the step count.

The upper output bits always come from the base register. A linear wrap therefore never carries into them. After the last beat, further advances go round the same four addresses again. When a strobe and advance arrive in the same cycle, the load wins and the advance is ignored.

Top module: `bgen_burst_addr`

## Requirements
- R1: While reset is asserted, and at the first clock after reset releases with no strobe and no advance, `burst_addr_o` is all zeros.
- R2: A clock rise with `strobe_a_n` low, `strobe_b_n` low, or both low loads the register state. From the next cycle, `burst_addr_o` equals the `addr_i` value sampled at that rise.
- R3: With `order_sel` = 0 (linear), each advance (`adv_n` low, no strobe) sets the low two bits to the previous low bits plus 1, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `order_sel` = 1 (interleaved), the k-th address after a load has low bits equal to the start value XOR k. For example, a start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R5: After four advances the output returns to the loaded address, and further advances repeat the same four addresses.
- R6: A clock rise with `adv_n` high and no strobe leaves `burst_addr_o` unchanged.
- R7: When a strobe and `adv_n` low occur at the same clock rise, the advance is ignored and the output equals the freshly loaded address.
- R8: Between loads, the bits of `burst_addr_o` above the low two never change, including when a linear step wraps from 11 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_a_n | input | 1 | First start strobe, active low |
| strobe_b_n | input | 1 | Second start strobe, active low |
| adv_n | input | 1 | Advance to the next burst beat, active low |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W (15) | Start address, sampled on a strobe |
| burst_addr_o | output | ADDR_W (15) | Current access address |

## Verification
A load and an advance can fall in the same clock cycle. The bench provokes this by asserting a strobe with advance held low, both at the start of an idle period and in the middle of a running burst. Each case is judged by requiring the next output to equal the new address exactly, with the step count back at zero. The following advance is then checked to confirm that it moves on from the new start value, not from the old sequence.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/bgen_seq.sv
// Holds the base address, the start value of the burst field and the step count.
module bgen_seq #(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      adv_n_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output logic [ADDR_W-BURST_W-1:0] base_o,
    output logic [BURST_W-1:0]        start_o,
    output logic [BURST_W-1:0]        step_o
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [UPPER_W-1:0] base;
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load_i) begin
            // a load outranks an advance in the same cycle
            seq_d.base  = addr_i[ADDR_W-1:BURST_W];
            seq_d.start = addr_i[BURST_W-1:0];
            seq_d.step  = '0;
        end else if (!adv_n_i) begin
            seq_d.step = seq_q.step + 1'b1;   // wraps at the burst length
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign base_o  = seq_q.base;
    assign start_o = seq_q.start;
    assign step_o  = seq_q.step;

    // R6: no strobe and no advance keeps all state
    a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(seq_q));

    // R5: the step count returns to zero after the last beat
    a_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && step_o == {BURST_W{1'b1}}) |=> step_o == '0);

endmodule

// File: rtl/bgen_order.sv
// Maps start value and step count to the burst field of the address.
module bgen_order
    import bgen_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  order_e             order_i,
    input  logic [BURST_W-1:0] start_i,
    input  logic [BURST_W-1:0] step_i,
    output logic [BURST_W-1:0] low_o
);
    logic [BURST_W-1:0] lin_w;
    logic [BURST_W-1:0] ilv_w;

    assign lin_w = start_i + step_i;   // modulo 2**BURST_W by width
    assign ilv_w = start_i ^ step_i;

    always_comb begin
        unique case (order_i)
            ORD_LINEAR:     low_o = lin_w;
            ORD_INTERLEAVE: low_o = ilv_w;
            default:        low_o = ilv_w;
        endcase
    end

endmodule

// File: rtl/bgen_burst_addr.sv
module bgen_burst_addr
    import bgen_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] burst_addr_o
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    logic               load_w;
    logic [UPPER_W-1:0] base_w;
    logic [BURST_W-1:0] start_w;
    logic [BURST_W-1:0] step_w;
    logic [BURST_W-1:0] low_w;
    order_e             order_w;

    assign load_w  = !strobe_a_n || !strobe_b_n;
    assign order_w = order_e'(order_sel);

    bgen_seq #(
        .ADDR_W (ADDR_W),
        .BURST_W(BURST_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .adv_n_i(adv_n),
        .addr_i (addr_i),
        .base_o (base_w),
        .start_o(start_w),
        .step_o (step_w)
    );

    bgen_order #(
        .BURST_W(BURST_W)
    ) u_order (
        .order_i(order_w),
        .start_i(start_w),
        .step_i (step_w),
        .low_o  (low_w)
    );

    assign burst_addr_o = {base_w, low_w};

    // R2, R7: a strobe loads the sampled address whatever adv_n is
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> burst_addr_o == $past(addr_i));

    // R8: upper bits only change on a load
    a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> burst_addr_o[ADDR_W-1:BURST_W] == $past(burst_addr_o[ADDR_W-1:BURST_W]));

    // R3: linear advance is an increment of the burst field
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !adv_n && order_sel == 1'b0)
        |=> burst_addr_o[BURST_W-1:0] == BURST_W'($past(burst_addr_o[BURST_W-1:0]) + 1'b1));

    // R4: every step of either order flips the lowest address bit
    a_r4_lsb_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !adv_n) |=> burst_addr_o[0] != $past(burst_addr_o[0]));

endmodule

// File: tb/sim_bgen_burst_addr.sv
module sim_bgen_burst_addr;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_a_n = 1'b1;
    logic          strobe_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] burst_addr_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bgen_burst_addr #(.ADDR_W(AW), .BURST_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n),
        .adv_n(adv_n), .order_sel(order_sel), .addr_i(addr_i), .burst_addr_o(burst_addr_o)
    );

    // {req[3:0], sa_n, sb_n, adv_n, order, addr[14:0], expected[14:0]}
    localparam int NV = 19;
    localparam logic [37:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 15'h1231, 15'h1231}, // R2 load via strobe A, linear
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 15'h1232}, // R3
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 15'h7FFF, 15'h1233}, // R3
        {4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 15'h1230}, // R8 wrap keeps upper bits
        {4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 15'h1231}, // R5 back to start
        {4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 15'h5555, 15'h1231}, // R6 hold
        {4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 15'h0A55, 15'h0A55}, // R2 load via strobe B, interleaved
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h0A54}, // R4
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h0A57}, // R4
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h0A56}, // R4
        {4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h0A55}, // R5
        {4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 15'h7FFE, 15'h7FFE}, // R2
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h7FFF}, // R4 start 10
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h7FFC}, // R4
        {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0000, 15'h7FFD}, // R4
        {4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0003, 15'h0003}, // R7 both strobes plus advance
        {4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 15'h0000}, // R8
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 15'h4446, 15'h4446}, // R7 load in mid burst
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, 15'h4447}  // R3 steps from new start
    };

    task automatic check(input int req, input logic [AW-1:0] exp);
        tests++;
        if (burst_addr_o !== exp) begin
            fails++;
            $display("FAIL R%0d: burst_addr_o=%h expected=%h", req, burst_addr_o, exp);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(1, '0);                       // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, '0);                       // R1 after release, idle

        for (int i = 0; i < NV; i++) begin
            strobe_a_n = VEC[i][33];
            strobe_b_n = VEC[i][32];
            adv_n      = VEC[i][31];
            order_sel  = VEC[i][30];
            addr_i     = VEC[i][29:15];
            @(negedge clk);
            check(int'(VEC[i][37:34]), VEC[i][14:0]);
        end

        // R1: reset in mid burst clears at once
        strobe_a_n = 1'b1; strobe_b_n = 1'b1; adv_n = 1'b1;
        #1 rst_n = 1'b0;
        #1 check(1, '0);
        @(negedge clk);
        rst_n = 1'b1;
        order_sel = 1'b0;
        // R3 advance from the reset state
        adv_n = 1'b0;
        @(negedge clk);
        check(3, 15'h0001);
        // R6 long hold
        adv_n = 1'b1;
        repeat (3) @(negedge clk);
        check(6, 15'h0001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule